// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic stage of a small microcontroller datapath. It takes two 8-bit operands and a 5-bit operation code. The second operand can come from a register or from an immediate field. It also takes the status byte currently held by the core. In the same cycle it returns the result, a write-enable for the destination register, and the next status byte. Each operation follows its own flag rules. Some flags are derived from the result bits rather than from a wide adder. The chained subtract and compare can clear Z but never set it, so a multi-byte compare ends with Z set only if every byte was equal.

The next status byte is also captured in a status register inside the block. The capture happens on a clock edge where the operation strobe is high, so a valid operation updates the flags one edge later. Bits 7:6 of the status byte are not ALU flags. They are always copied from the incoming status byte.

Top module: `mcu_alu8`

## Requirements
- R1: Codes 0 (add) and 1 (add with carry) produce a + b (+ C). C is the carry out of bit 7, H is the carry out of bit 3, and V is set on two's-complement overflow. Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5.
- R2: Codes 2 (subtract) and 3 (subtract with carry) produce a - b (- C) and write it back. C is the borrow into bit 7 from above, H is the borrow out of bit 3, and V is set on signed overflow.
- R3: Codes 4 (compare) and 5 (compare with carry) set the flags exactly as codes 2 and 3 do and show the difference on `result`, but `result_we` stays low.
- R4: For codes 3 and 5, next Z is the old Z AND (result == 0). A zero result leaves Z as it was and a nonzero result clears it.
- R5: Every flag-updating operation sets N to result bit 7 and S to N XOR V. Except as R4 states, Z is set exactly when the result is zero.
- R6: Code 11 (increment) sets V only when the operand was 0x7F. Code 12 (decrement) sets V only when the result is 0x7F. Both leave C and H unchanged.
- R7: Code 10 (negate) produces 0 - a. V is set when the result is 0x80, C is set when the result is nonzero, and H = result bit 3 OR operand bit 3.
- R8: Codes 6 (AND), 7 (OR) and 8 (XOR) clear V and keep C and H. Code 9 (bitwise invert) clears V, sets C and keeps H.
- R9: Codes 13 (arithmetic right shift, bit 7 kept), 14 (logical right shift, bit 7 = 0) and 15 (rotate right, old C into bit 7) load C from operand bit 0, set V = N XOR C and keep H.
- R10: Code 16 exchanges the operand's two nibbles, writes the result back, and leaves every flag unchanged.
- R11: Codes 17 to 31 keep `result_we` low and pass the whole status byte through unchanged.
- R12: `result_we` is high only while `op_valid` is high and the operation writes a result. Bits 7:6 of `status_next` always equal those of `status_in`.
- R13: Reset clears `status_q` to 0x00. `status_q` loads `status_next` on a rising edge where `op_valid` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe; enables write-back and status capture |
| op_sel | input | 5 | Operation code |
| opnd_a | input | 8 | First operand (destination register value) |
| opnd_b | input | 8 | Second operand (register or immediate) |
| status_in | input | 8 | Current status byte |
| result | output | 8 | Operation result |
| result_we | output | 1 | Destination write-enable |
| status_next | output | 8 | Next status byte |
| status_q | output | 8 | Registered status byte |

## Verification
The assertions assume that `op_sel`, both operands and `status_in` carry known values whenever reset is inactive. They also assume these inputs hold steady for a whole clock period, so the combinational outputs settle before the capturing edge. The bench changes every input only on the falling edge and leaves `op_valid` low throughout reset. It sweeps all 32 operation codes with directed corner operands and random operands and status bytes. That sweep includes codes that do not exist and cycles where the strobe is low.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int STATUS_W = 8;
  localparam int FLAG_W   = 6;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,
    OP_CMPC = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_INV  = 5'd9,
    OP_NEG  = 5'd10,
    OP_INC  = 5'd11,
    OP_DEC  = 5'd12,
    OP_ASR  = 5'd13,
    OP_LSR  = 5'd14,
    OP_ROR  = 5'd15,
    OP_SWAP = 5'd16
  } alu_op_e;

  // Packed order places c at bit 0 up to h at bit 5 of the status byte.
  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } alu_flags_t;

  typedef enum logic [1:0] {
    UNIT_ARITH,
    UNIT_LOGIC,
    UNIT_SHIFT,
    UNIT_NONE
  } unit_sel_e;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e             op,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  alu_flags_t          flags_in,
  output logic [DATA_W-1:0]   res,
  output alu_flags_t          flags_out
);

  localparam int MSB = DATA_W - 1;
  localparam int HB  = DATA_W / 2 - 1;
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] ONE     = {{(DATA_W-1){1'b0}}, 1'b1};

  function automatic logic carry_at(input logic x, input logic y, input logic r);
    return (x & y) | (y & ~r) | (~r & x);
  endfunction

  function automatic logic borrow_at(input logic x, input logic y, input logic r);
    return (~x & y) | (y & r) | (r & ~x);
  endfunction

  logic [DATA_W-1:0] lhs;
  logic [DATA_W-1:0] rhs;
  logic              cin;
  logic              do_sub;
  logic [DATA_W-1:0] cin_ext;
  logic              is_zero;

  // operand steering
  always_comb begin
    lhs    = a;
    rhs    = b;
    cin    = 1'b0;
    do_sub = 1'b0;
    case (op)
      OP_ADC:          cin = flags_in.c;
      OP_SUB, OP_CMP:  do_sub = 1'b1;
      OP_SBC, OP_CMPC: begin
        do_sub = 1'b1;
        cin    = flags_in.c;
      end
      OP_INC:          rhs = ONE;
      OP_DEC: begin
        rhs    = ONE;
        do_sub = 1'b1;
      end
      OP_NEG: begin
        lhs    = '0;
        rhs    = a;
        do_sub = 1'b1;
      end
      default: ;
    endcase
  end

  assign cin_ext = {{(DATA_W-1){1'b0}}, cin};
  assign res     = do_sub ? (lhs - rhs - cin_ext) : (lhs + rhs + cin_ext);
  assign is_zero = (res == '0);

  // flag rules per operation
  always_comb begin
    flags_out = flags_in;
    case (op)
      OP_ADD, OP_ADC: begin
        flags_out.h = carry_at(lhs[HB], rhs[HB], res[HB]);
        flags_out.c = carry_at(lhs[MSB], rhs[MSB], res[MSB]);
        flags_out.v = (lhs[MSB] & rhs[MSB] & ~res[MSB]) |
                      (~lhs[MSB] & ~rhs[MSB] & res[MSB]);
      end
      OP_SUB, OP_SBC, OP_CMP, OP_CMPC: begin
        flags_out.h = borrow_at(lhs[HB], rhs[HB], res[HB]);
        flags_out.c = borrow_at(lhs[MSB], rhs[MSB], res[MSB]);
        flags_out.v = (lhs[MSB] & ~rhs[MSB] & ~res[MSB]) |
                      (~lhs[MSB] & rhs[MSB] & res[MSB]);
      end
      OP_INC: flags_out.v = (a == MAX_POS);
      OP_DEC: flags_out.v = (res == MAX_POS);
      OP_NEG: begin
        flags_out.h = res[HB] | a[HB];
        flags_out.v = (res == MIN_NEG);
        flags_out.c = ~is_zero;
      end
      default: ;
    endcase
    flags_out.n = res[MSB];
    flags_out.s = flags_out.n ^ flags_out.v;
    if ((op == OP_SBC) || (op == OP_CMPC)) begin
      flags_out.z = flags_in.z & is_zero;
    end else begin
      flags_out.z = is_zero;
    end
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e             op,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  alu_flags_t          flags_in,
  output logic [DATA_W-1:0]   res,
  output alu_flags_t          flags_out
);

  localparam int MSB  = DATA_W - 1;
  localparam int HALF = DATA_W / 2;

  logic updates;

  always_comb begin
    res     = a;
    updates = 1'b1;
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_INV:  res = ~a;
      OP_SWAP: begin
        res     = {a[HALF-1:0], a[MSB:HALF]};
        updates = 1'b0;
      end
      default: updates = 1'b0;
    endcase
  end

  always_comb begin
    flags_out = flags_in;
    if (updates) begin
      flags_out.v = 1'b0;
      flags_out.n = res[MSB];
      flags_out.s = res[MSB];
      flags_out.z = (res == '0);
      if (op == OP_INV) begin
        flags_out.c = 1'b1;
      end
    end
  end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e             op,
  input  logic [DATA_W-1:0]   a,
  input  alu_flags_t          flags_in,
  output logic [DATA_W-1:0]   res,
  output alu_flags_t          flags_out
);

  localparam int MSB = DATA_W - 1;

  logic fill;

  always_comb begin
    case (op)
      OP_ASR:  fill = a[MSB];
      OP_ROR:  fill = flags_in.c;
      default: fill = 1'b0;
    endcase
  end

  assign res = {fill, a[MSB:1]};

  always_comb begin
    flags_out   = flags_in;
    flags_out.c = a[0];
    flags_out.n = res[MSB];
    flags_out.v = res[MSB] ^ a[0];
    flags_out.s = flags_out.n ^ flags_out.v;
    flags_out.z = (res == '0);
  end

endmodule

// File: rtl/alu8_status_reg.sv
module alu8_status_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic bit_q;
    logic bit_nxt;

    always_comb begin
      bit_nxt = load ? d[i] : bit_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else begin
        bit_q <= bit_nxt;
      end
    end

    assign q[i] = bit_q;
  end

endmodule

// File: rtl/mcu_alu8.sv
module mcu_alu8
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [4:0]          op_sel,
  input  logic [DATA_W-1:0]   opnd_a,
  input  logic [DATA_W-1:0]   opnd_b,
  input  logic [STATUS_W-1:0] status_in,
  output logic [DATA_W-1:0]   result,
  output logic                result_we,
  output logic [STATUS_W-1:0] status_next,
  output logic                [STATUS_W-1:0] status_q
);

  alu_op_e     op;
  unit_sel_e   unit;
  logic        writes;
  alu_flags_t  flags_cur;
  alu_flags_t  fl_arith, fl_logic, fl_shift;
  alu_flags_t  flags_sel;
  logic [DATA_W-1:0] r_arith, r_logic, r_shift;

  assign op        = alu_op_e'(op_sel);
  assign flags_cur = alu_flags_t'(status_in[FLAG_W-1:0]);

  // operation class decode
  always_comb begin
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMPC,
      OP_NEG, OP_INC, OP_DEC:                  unit = UNIT_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_INV, OP_SWAP:  unit = UNIT_LOGIC;
      OP_ASR, OP_LSR, OP_ROR:                  unit = UNIT_SHIFT;
      default:                                 unit = UNIT_NONE;
    endcase
    writes = (unit != UNIT_NONE) && (op != OP_CMP) && (op != OP_CMPC);
  end

  alu8_arith #(.DATA_W(DATA_W)) u_arith (
    .op        (op),
    .a         (opnd_a),
    .b         (opnd_b),
    .flags_in  (flags_cur),
    .res       (r_arith),
    .flags_out (fl_arith)
  );

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .op        (op),
    .a         (opnd_a),
    .b         (opnd_b),
    .flags_in  (flags_cur),
    .res       (r_logic),
    .flags_out (fl_logic)
  );

  alu8_shift #(.DATA_W(DATA_W)) u_shift (
    .op        (op),
    .a         (opnd_a),
    .flags_in  (flags_cur),
    .res       (r_shift),
    .flags_out (fl_shift)
  );

  // result and flag select
  always_comb begin
    case (unit)
      UNIT_ARITH: begin
        result    = r_arith;
        flags_sel = fl_arith;
      end
      UNIT_LOGIC: begin
        result    = r_logic;
        flags_sel = fl_logic;
      end
      UNIT_SHIFT: begin
        result    = r_shift;
        flags_sel = fl_shift;
      end
      default: begin
        result    = '0;
        flags_sel = flags_cur;
      end
    endcase
  end

  assign result_we   = op_valid & writes;
  assign status_next = {status_in[STATUS_W-1:FLAG_W], flags_sel};

  alu8_status_reg #(.WIDTH(STATUS_W)) u_sreg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (op_valid),
    .d     (status_next),
    .q     (status_q)
  );

endmodule

// File: rtl/mcu_alu8_chk.sv
module mcu_alu8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [4:0] op_sel,
  input logic [7:0] opnd_a,
  input logic [7:0] status_in,
  input logic [7:0] result,
  input logic       result_we,
  input logic [7:0] status_next,
  input logic [7:0] status_q
);

  a_r3_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 5'd4 || op_sel == 5'd5) |-> !result_we);

  a_r4_chain_z_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_sel == 5'd3 || op_sel == 5'd5) && !status_in[1]) |-> !status_next[1]);

  a_r5_n_and_s: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel <= 5'd15) |->
      (status_next[2] == result[7]) && (status_next[4] == (status_next[2] ^ status_next[3])));

  a_r6_incdec_keep_c: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 5'd11 || op_sel == 5'd12) |->
      (status_next[0] == status_in[0]) && (status_next[5] == status_in[5]));

  a_r9_shift_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel >= 5'd13 && op_sel <= 5'd15) |-> (status_next[0] == opnd_a[0]));

  a_r10_swap_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 5'd16) |-> (status_next == status_in));

  a_r11_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > 5'd16) |-> (!result_we && status_next == status_in));

  a_r12_we_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !result_we);

  a_r13_load: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (status_q == $past(status_next)));

  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(status_q));

endmodule

bind mcu_alu8 mcu_alu8_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid    (op_valid),
  .op_sel      (op_sel),
  .opnd_a      (opnd_a),
  .status_in   (status_in),
  .result      (result),
  .result_we   (result_we),
  .status_next (status_next),
  .status_q    (status_q)
);

// File: tb/mcu_alu8_tb_top.sv
module mcu_alu8_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic       clk;
  logic       rst_n;
  logic       op_valid;
  logic [4:0] op_sel;
  logic [7:0] opnd_a, opnd_b, status_in;
  logic [7:0] result;
  logic       result_we;
  logic [7:0] status_next, status_q;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  typedef struct {
    logic [4:0] op;
    logic       we;
    logic [7:0] res;
    logic [7:0] stn;
    logic [7:0] sq;
    string      tag;
  } exp_item_t;

  exp_item_t exp_q[$];
  logic [7:0] model_sq;

  mcu_alu8 dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_sel      (op_sel),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .status_in   (status_in),
    .result      (result),
    .result_we   (result_we),
    .status_next (status_next),
    .status_q    (status_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // Reference: {we, result, status_next}
  function automatic logic [16:0] ref_model(input logic [4:0] op, input logic [7:0] a,
                                            input logic [7:0] b, input logic [7:0] st);
    int ai, bi, sa, sb, ci, t;
    logic [7:0] r, ns;
    logic we, upd, shift;
    ai = int'(a); bi = int'(b);
    sa = int'($signed(a)); sb = int'($signed(b));
    ns = st; we = 1'b0; r = 8'h00; upd = 1'b1; shift = 1'b0; ci = 0;
    case (op)
      5'd0, 5'd1: begin
        ci = (op == 5'd1) ? int'(st[0]) : 0;
        t = ai + bi + ci; r = t[7:0];
        ns[0] = (t > 255);
        ns[5] = ((ai % 16) + (bi % 16) + ci) > 15;
        t = sa + sb + ci; ns[3] = (t > 127) || (t < -128);
        we = 1'b1;
      end
      5'd2, 5'd3, 5'd4, 5'd5: begin
        ci = (op == 5'd3 || op == 5'd5) ? int'(st[0]) : 0;
        t = ai - bi - ci; r = t[7:0];
        ns[0] = ai < (bi + ci);
        ns[5] = (ai % 16) < ((bi % 16) + ci);
        t = sa - sb - ci; ns[3] = (t > 127) || (t < -128);
        we = (op < 5'd4);
      end
      5'd6:  begin r = a & b; ns[3] = 1'b0; we = 1'b1; end
      5'd7:  begin r = a | b; ns[3] = 1'b0; we = 1'b1; end
      5'd8:  begin r = a ^ b; ns[3] = 1'b0; we = 1'b1; end
      5'd9:  begin r = ~a; ns[3] = 1'b0; ns[0] = 1'b1; we = 1'b1; end
      5'd10: begin
        r = 8'h00 - a; ns[5] = r[3] | a[3]; ns[3] = (r == 8'h80);
        ns[0] = (r != 8'h00); we = 1'b1;
      end
      5'd11: begin r = a + 8'h01; ns[3] = (a == 8'h7F); we = 1'b1; end
      5'd12: begin r = a - 8'h01; ns[3] = (r == 8'h7F); we = 1'b1; end
      5'd13: begin r = {a[7], a[7:1]}; ns[0] = a[0]; shift = 1'b1; we = 1'b1; end
      5'd14: begin r = {1'b0, a[7:1]}; ns[0] = a[0]; shift = 1'b1; we = 1'b1; end
      5'd15: begin r = {st[0], a[7:1]}; ns[0] = a[0]; shift = 1'b1; we = 1'b1; end
      5'd16: begin r = {a[3:0], a[7:4]}; upd = 1'b0; we = 1'b1; end
      default: begin upd = 1'b0; we = 1'b0; end
    endcase
    if (upd) begin
      ns[2] = r[7];
      if (shift) ns[3] = ns[2] ^ ns[0];
      ns[4] = ns[2] ^ ns[3];
      if (op == 5'd3 || op == 5'd5) ns[1] = st[1] && (r == 8'h00);
      else ns[1] = (r == 8'h00);
    end
    return {we, r, ns};
  endfunction

  // driver: pushes the expected item for each applied operation
  task automatic apply(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] st, input logic v, input string tag);
    logic [16:0] m;
    exp_item_t it;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; status_in = st; op_valid = v;
    m = ref_model(op, a, b, st);
    if (v) model_sq = m[7:0];
    it.op  = op;
    it.we  = m[16] & v;
    it.res = m[15:8];
    it.stn = m[7:0];
    it.sq  = model_sq;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor: compares a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        exp_item_t it;
        it = exp_q.pop_front();
        if (it.op <= 5'd16) check(it.tag, "result", result, it.res);
        check(it.tag, "result_we", {7'b0, result_we}, {7'b0, it.we});
        check(it.tag, "status_next", status_next, it.stn);
        check(it.tag, "status_q R13", status_q, it.sq);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_sel = 5'd0;
    opnd_a = 8'h00; opnd_b = 8'h00; status_in = 8'h00; model_sq = 8'h00;
    repeat (3) @(negedge clk);
    // reset state, R13 and R12
    check("R13", "status_q after reset", status_q, 8'h00);
    check("R12", "result_we idle", {7'b0, result_we}, 8'h00);
    rst_n = 1'b1;

    // R1 add / add with carry
    apply(5'd0, 8'h0F, 8'h01, 8'h00, 1'b1, "R1");
    apply(5'd0, 8'h7F, 8'h01, 8'h00, 1'b1, "R1");
    apply(5'd0, 8'hFF, 8'h01, 8'hC0, 1'b1, "R1");
    apply(5'd1, 8'hFF, 8'h00, 8'h01, 1'b1, "R1");
    apply(5'd1, 8'h80, 8'h80, 8'h00, 1'b1, "R1");
    // R2 subtract / subtract with carry
    apply(5'd2, 8'h00, 8'h01, 8'h00, 1'b1, "R2");
    apply(5'd2, 8'h80, 8'h01, 8'h00, 1'b1, "R2");
    apply(5'd3, 8'h10, 8'h0F, 8'h01, 1'b1, "R2");
    // R3 compare
    apply(5'd4, 8'h42, 8'h42, 8'h00, 1'b1, "R3");
    apply(5'd4, 8'h01, 8'h02, 8'h00, 1'b1, "R3");
    // R4 chained Z
    apply(5'd5, 8'h05, 8'h04, 8'h03, 1'b1, "R4");
    apply(5'd5, 8'h05, 8'h04, 8'h01, 1'b1, "R4");
    apply(5'd3, 8'h07, 8'h07, 8'h02, 1'b1, "R4");
    apply(5'd3, 8'h07, 8'h07, 8'h00, 1'b1, "R4");
    apply(5'd5, 8'h09, 8'h03, 8'h02, 1'b1, "R4");
    // R5 zero result on logic
    apply(5'd6, 8'hF0, 8'h0F, 8'h21, 1'b1, "R5");
    // R6 inc / dec
    apply(5'd11, 8'h7F, 8'h00, 8'h21, 1'b1, "R6");
    apply(5'd11, 8'hFF, 8'h00, 8'h00, 1'b1, "R6");
    apply(5'd12, 8'h80, 8'h00, 8'h21, 1'b1, "R6");
    apply(5'd12, 8'h01, 8'h00, 8'h00, 1'b1, "R6");
    // R7 negate
    apply(5'd10, 8'h80, 8'h00, 8'h00, 1'b1, "R7");
    apply(5'd10, 8'h00, 8'h00, 8'h01, 1'b1, "R7");
    apply(5'd10, 8'h08, 8'h00, 8'h00, 1'b1, "R7");
    // R8 logic and invert
    apply(5'd7, 8'h80, 8'h01, 8'h29, 1'b1, "R8");
    apply(5'd8, 8'hAA, 8'hAA, 8'h21, 1'b1, "R8");
    apply(5'd9, 8'hFF, 8'h00, 8'h28, 1'b1, "R8");
    // R9 shifts
    apply(5'd13, 8'h81, 8'h00, 8'h20, 1'b1, "R9");
    apply(5'd14, 8'h81, 8'h00, 8'h00, 1'b1, "R9");
    apply(5'd15, 8'h01, 8'h00, 8'h01, 1'b1, "R9");
    apply(5'd15, 8'h02, 8'h00, 8'h00, 1'b1, "R9");
    // R10 swap
    apply(5'd16, 8'h3C, 8'h00, 8'h3F, 1'b1, "R10");
    // R11 unused codes
    apply(5'd17, 8'h12, 8'h34, 8'hA5, 1'b1, "R11");
    apply(5'd31, 8'hFF, 8'hFF, 8'h5A, 1'b1, "R11");
    // R12 / R13 strobe low
    apply(5'd0, 8'h01, 8'h01, 8'hFF, 1'b0, "R12");
    apply(5'd2, 8'h00, 8'h05, 8'h00, 1'b0, "R13");

    // random sweep over every code
    for (int k = 0; k < 1200; k++) begin
      logic [4:0] op;
      op = 5'(k % 32);
      apply(op, 8'($urandom), 8'($urandom), 8'($urandom), ($urandom % 4) != 0, "R5");
    end

    @(negedge clk);
    op_valid = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule